// File: doc/BRIEF.md
# Programmable-Priority Interrupt Router

This block gathers 32 level-sensitive interrupt request lines and steers each one to exactly one of two processor inputs: a fast interrupt line (FIQ) or a normal interrupt line (IRQ). Software programs three registers through a small write/read port:

- a per-source enable mask;
- a per-source class select;
- a priority word that gives each of the eight lowest-numbered sources a 3-bit urgency level.

For each output class the block arbitrates among the requests that are pending, enabled and routed to that class. It drives the class line together with the 5-bit number of the winning source.

Arbitration and masking are purely combinational. Their result is captured in one register stage, so the outputs follow the inputs with a latency of one clock. Sources 8 and above have no programmable level. They always rank below the programmable group and are ordered among themselves by source number. A handler reads the winning number from the index output and services that source directly.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable word is 0 and the select word is 0. The priority field of source i holds the value i, so the priority word reads 0x00FAC688. Both class outputs are low.
- R2: A source whose enable bit (bit i of the word at address 0) is 0 never causes `fiq_o` or `irq_o` to assert, whatever its input level.
- R3: The select word is at address 1. Bit i = 1 routes source i to the FIQ class and bit i = 0 routes it to the IRQ class. A source is never reported on both outputs. Writing 0x00000005 makes sources 0 and 2 FIQ sources.
- R4: The priority word is at address 2. Source i (0 to 7) takes its level from bits 3i+2:3i. Level 0 is the most urgent and level 7 the least. Within a class the most urgent pending, enabled source wins.
- R5: Among sources 0 to 7 at equal levels, the lower source number wins. For example, sources 1 and 3 both at level 0 resolve to 1.
- R6: Every source from 8 to 31 ranks below every source from 0 to 7, whatever the level of those sources. Among sources 8 to 31 the lower number wins.
- R7: The class line and index outputs reflect the request, enable and select state sampled at the preceding rising clock edge. There is exactly one cycle of latency from `irq_src_i` to the outputs.
- R8: A write with `cfg_we_i` high takes effect at the clock edge that samples it. A read returns the current contents at the addressed location (0 enable, 1 select, 2 priority with bits 31:24 reading 0, 3 raw `irq_src_i`). A write to address 3 changes nothing.
- R9: While a class line is low, its index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Level-sensitive interrupt requests, bit i is source i |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` (combinational) |
| fiq_o | output | 1 | Fast interrupt request, also the valid flag for `fiq_id_o` |
| fiq_id_o | output | 5 | Number of the winning FIQ-class source |
| irq_o | output | 1 | Normal interrupt request, also the valid flag for `irq_id_o` |
| irq_id_o | output | 5 | Number of the winning IRQ-class source |

## Verification
The hardest situation to reach from the ports is a contest that only the priority logic decides. This needs several enabled requests in the same class, with equal or inverted programmed levels, while requests from the fixed-order group are pending at the same time. The directed stimulus sets up exactly that: it reprograms the levels so that source 0 becomes the least urgent, ties sources 1 and 3 at level 0, and holds high-numbered sources active. A long random phase then writes random levels, masks and selects while the requests change every cycle. A behavioural model computes the winner by an exhaustive ranking and checks it each clock.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_SEL  = 2'd1,
    REG_PRIO = 2'd2,
    REG_PEND = 2'd3
  } pic_reg_e;

  localparam int unsigned CLS_IRQ = 0;
  localparam int unsigned CLS_FIQ = 1;
  localparam int unsigned N_CLS   = 2;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 8,
  parameter int unsigned PW     = 3,
  localparam int unsigned PRIO_W = N_PRIO * PW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  pend_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  sel_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [N_SRC-1:0]  rdata_o
);
  logic [PRIO_W-1:0] prio_rst;
  logic [N_SRC-1:0]  en_q, sel_q;
  logic [PRIO_W-1:0] prio_q;
  pic_reg_e          reg_a;

  assign reg_a = pic_reg_e'(addr_i);

  // Reset levels equal the source number: fixed ordering by default.
  for (genvar g = 0; g < N_PRIO; g++) begin : g_prst
    assign prio_rst[g*PW +: PW] = PW'(g);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      sel_q  <= '0;
      prio_q <= prio_rst;
    end else if (we_i) begin
      case (reg_a)
        REG_EN:   en_q   <= wdata_i;
        REG_SEL:  sel_q  <= wdata_i;
        REG_PRIO: prio_q <= wdata_i[PRIO_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_a)
      REG_EN:   rdata_o = en_q;
      REG_SEL:  rdata_o = sel_q;
      REG_PRIO: rdata_o = N_SRC'(prio_q);
      default:  rdata_o = pend_i;
    endcase
  end

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 8,
  parameter int unsigned PW     = 3,
  localparam int unsigned IDXW  = $clog2(N_SRC),
  localparam int unsigned KW    = 1 + PW + IDXW
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_PRIO*PW-1:0]   prio_i,
  output logic                   vld_o,
  output logic [IDXW-1:0]        idx_o
);
  // Rank key {tier, level, number}: smallest key wins, number breaks ties.
  logic [KW-1:0] key [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_key
    if (g < N_PRIO) begin : g_prog
      assign key[g] = {1'b0, prio_i[g*PW +: PW], IDXW'(g)};
    end else begin : g_fixed
      assign key[g] = {1'b1, {PW{1'b0}}, IDXW'(g)};
    end
  end

  logic [KW-1:0] best_key;

  always_comb begin
    vld_o    = 1'b0;
    idx_o    = '0;
    best_key = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (!vld_o || key[i] < best_key)) begin
        vld_o    = 1'b1;
        best_key = key[i];
        idx_o    = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 8,
  parameter int unsigned PW     = 3,
  localparam int unsigned IDXW  = $clog2(N_SRC),
  localparam int unsigned PRIO_W = N_PRIO * PW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [N_SRC-1:0] cfg_wdata_i,
  output logic [N_SRC-1:0] cfg_rdata_o,
  output logic             fiq_o,
  output logic [IDXW-1:0]  fiq_id_o,
  output logic             irq_o,
  output logic [IDXW-1:0]  irq_id_o
);
  logic [N_SRC-1:0]  en_q, sel_q;
  logic [PRIO_W-1:0] prio_q;

  pic_regs #(.N_SRC(N_SRC), .N_PRIO(N_PRIO), .PW(PW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .pend_i  (irq_src_i),
    .en_o    (en_q),
    .sel_o   (sel_q),
    .prio_o  (prio_q),
    .rdata_o (cfg_rdata_o)
  );

  logic [N_SRC-1:0] cls_req [N_CLS];
  logic [N_CLS-1:0] hit_d, hit_q;
  logic [IDXW-1:0]  id_d [N_CLS];
  logic [IDXW-1:0]  id_q [N_CLS];

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    if (c == CLS_FIQ) begin : g_fiq
      assign cls_req[c] = irq_src_i & en_q & sel_q;
    end else begin : g_irq
      assign cls_req[c] = irq_src_i & en_q & ~sel_q;
    end

    pic_arb #(.N_SRC(N_SRC), .N_PRIO(N_PRIO), .PW(PW)) u_arb (
      .req_i  (cls_req[c]),
      .prio_i (prio_q),
      .vld_o  (hit_d[c]),
      .idx_o  (id_d[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_q[c] <= 1'b0;
        id_q[c]  <= '0;
      end else begin
        hit_q[c] <= hit_d[c];
        id_q[c]  <= id_d[c];
      end
    end
  end

  assign fiq_o    = hit_q[CLS_FIQ];
  assign fiq_id_o = id_q[CLS_FIQ];
  assign irq_o    = hit_q[CLS_IRQ];
  assign irq_id_o = id_q[CLS_IRQ];
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_PRIO = 8,
  localparam int unsigned IDXW  = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] irq_src_i,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_addr_i,
  input logic [N_SRC-1:0] cfg_wdata_i,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] sel_q,
  input logic             fiq_o,
  input logic [IDXW-1:0]  fiq_id_o,
  input logic             irq_o,
  input logic [IDXW-1:0]  irq_id_o
);
  logic [N_SRC-1:0] fiq_req_q, irq_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fiq_req_q <= '0;
      irq_req_q <= '0;
    end else begin
      fiq_req_q <= irq_src_i & en_q & sel_q;
      irq_req_q <= irq_src_i & en_q & ~sel_q;
    end
  end

  p_masked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(irq_src_i & en_q)) |=> (!fiq_o && !irq_o));

  p_one_class_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o && irq_o) |-> (fiq_id_o != irq_id_o));

  p_fiq_winner_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> fiq_req_q[fiq_id_o]);

  p_irq_winner_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_req_q[irq_id_o]);

  p_fixed_below_prog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && |irq_req_q[N_PRIO-1:0]) |-> (irq_id_o < IDXW'(N_PRIO)));

  p_sel_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == 2'd1) |=> (sel_q == $past(cfg_wdata_i)));

  p_idle_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fiq_o |-> fiq_id_o == '0) and (!irq_o |-> irq_id_o == '0));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_src_i   (irq_src_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .en_q        (en_q),
  .sel_q       (sel_q),
  .fiq_o       (fiq_o),
  .fiq_id_o    (fiq_id_o),
  .irq_o       (irq_o),
  .irq_id_o    (irq_id_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        fiq, irq;
  logic [4:0]  fiq_id, irq_id;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wd), .cfg_rdata_o(rdata),
    .fiq_o(fiq), .fiq_id_o(fiq_id), .irq_o(irq), .irq_id_o(irq_id)
  );

  // Behavioural reference model
  logic [31:0] m_en, m_sel;
  int          m_pr [8];
  bit          e_fiq, e_irq;
  int          e_fid, e_iid;

  function automatic void rank(input bit cls, output bit v, output int id);
    int best = 1 << 30;
    v = 0; id = 0;
    for (int i = 0; i < 32; i++) begin
      if (src[i] && m_en[i] && (m_sel[i] == cls)) begin
        int k = (i < 8) ? (m_pr[i] * 64 + i) : (10000 + i);
        if (k < best) begin best = k; v = 1; id = i; end
      end
    end
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] r = '0;
    case (a)
      2'd0: r = m_en;
      2'd1: r = m_sel;
      2'd2: for (int i = 0; i < 8; i++) r = r | (32'(m_pr[i]) << (3 * i));
      default: r = src;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '0; m_sel = '0;
      for (int i = 0; i < 8; i++) m_pr[i] = i;
      e_fiq = 0; e_irq = 0; e_fid = 0; e_iid = 0;
    end else begin
      bit v; int id;
      rank(1'b1, v, id); e_fiq = v; e_fid = id;
      rank(1'b0, v, id); e_irq = v; e_iid = id;
      if (we) begin
        case (addr)
          2'd0: m_en = wd;
          2'd1: m_sel = wd;
          2'd2: for (int i = 0; i < 8; i++) m_pr[i] = int'((wd >> (3 * i)) & 32'd7);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Compare against the model at the falling edge, then drive the next cycle.
  task automatic drive(input logic [31:0] s, input logic w, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    chk("R7 fiq line", 32'(fiq), 32'(e_fiq));
    chk("R7 fiq index", 32'(fiq_id), 32'(e_fid));
    chk("R7 irq line", 32'(irq), 32'(e_irq));
    chk("R7 irq index", 32'(irq_id), 32'(e_iid));
    src = s; we = w; addr = a; wd = d;
  endtask

  task automatic idle(input int n, input logic [31:0] s);
    for (int i = 0; i < n; i++) drive(s, 1'b0, 2'd0, '0);
  endtask

  task automatic rd(input string tag, input logic [31:0] s, input logic [1:0] a, input logic [31:0] exp);
    drive(s, 1'b0, a, '0);
    #1 chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd("R1 enable reset", '0, 2'd0, 32'h0);
    rd("R1 select reset", '0, 2'd1, 32'h0);
    rd("R1 priority reset", '0, 2'd2, 32'h00FA_C688);
    chk("R1 outputs low", 32'({fiq, irq}), 32'd0);

    // R2: everything requesting, nothing enabled
    idle(3, '1);
    chk("R2 masked fiq", 32'(fiq), 32'd0);
    chk("R2 masked irq", 32'(irq), 32'd0);

    // R3: default routing is IRQ
    drive('1, 1'b1, 2'd0, '1);
    idle(3, '1);
    chk("R3 default fiq", 32'(fiq), 32'd0);
    chk("R3 default irq id", 32'(irq_id), 32'd0);

    drive('1, 1'b1, 2'd1, 32'h5);
    idle(3, '1);
    chk("R3 fiq line", 32'(fiq), 32'd1);
    chk("R3 fiq id", 32'(fiq_id), 32'd0);
    chk("R3 irq id", 32'(irq_id), 32'd1);
    rd("R8 select readback", '1, 2'd1, 32'h5);

    // R4/R5: source 0 least urgent, sources 1 and 3 tied at 0
    drive('1, 1'b1, 2'd2, 32'h00FA_C087);
    idle(3, '1);
    chk("R4 fiq reprioritised", 32'(fiq_id), 32'd2);
    chk("R5 tie lower wins", 32'(irq_id), 32'd1);
    rd("R8 priority readback", '1, 2'd2, 32'h00FA_C087);
    idle(3, 32'hFFFF_FFFD);
    chk("R4 level 0 beats rest", 32'(irq_id), 32'd3);

    // R6: fixed-order group
    idle(3, 32'hF000_0000);
    chk("R6 high sources order", 32'(irq_id), 32'd28);
    chk("R6 no fiq", 32'(fiq), 32'd0);
    idle(3, 32'h8000_0080);
    chk("R6 level 7 beats 31", 32'(irq_id), 32'd7);
    idle(3, 32'h8000_0100);
    chk("R6 8 beats 31", 32'(irq_id), 32'd8);

    // R9 and R7: idle index, then one-cycle latency
    idle(3, '0);
    chk("R9 idle fiq id", 32'(fiq_id), 32'd0);
    chk("R9 idle irq id", 32'(irq_id), 32'd0);
    drive(32'h400, 1'b0, 2'd0, '0);
    drive(32'h400, 1'b0, 2'd0, '0);
    chk("R7 latency line", 32'(irq), 32'd1);
    chk("R7 latency id", 32'(irq_id), 32'd10);

    // R8: disable write takes effect at its edge, output follows one edge later
    drive(32'h400, 1'b1, 2'd0, '0);
    drive(32'h400, 1'b0, 2'd0, '0);
    chk("R8 old enable at write edge", 32'(irq), 32'd1);
    drive(32'h400, 1'b0, 2'd0, '0);
    chk("R2 disabled after write", 32'(irq), 32'd0);

    // R8: pending read, write to address 3 ignored
    rd("R8 pending read", 32'h1234_5678, 2'd3, 32'h1234_5678);
    drive(32'h1234_5678, 1'b1, 2'd3, '1);
    rd("R8 enable unchanged", '0, 2'd0, 32'h0);
    rd("R8 select unchanged", '0, 2'd1, 32'h5);
    rd("R8 priority unchanged", '0, 2'd2, 32'h00FA_C087);

    // Random phase: model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] s = $urandom;
      logic        w = ($urandom % 6) == 0;
      logic [1:0]  a = 2'($urandom);
      logic [31:0] d = $urandom;
      if ((n % 17) == 0) s = '0;
      if ((n % 5) == 0) d = d & 32'h0049_2492;
      drive(s, w, a, d);
      #1 chk("R8 random readback", rdata, m_read(a));
    end
    idle(2, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule